// File: doc/BRIEF.md
# Critical-Chunk-First Line Unpacker

This block takes one complete cache-line read (sixty-four data bytes and eight check bytes, delivered as a single 576-bit word) and sends it out as four 18-byte beats on a narrower data path. Each beat carries a 16-byte data chunk and the two check bytes that protect that chunk. The chunk that holds the missed address goes out first. The remaining chunks follow in wrapping order, so the requester gets its critical word after a single beat.

A line is offered with a valid/ready handshake, along with the byte offset of the miss inside the line. Once a line is accepted, the block runs a small two-state machine. In `ST_IDLE` it offers `line_ready`. The transition *load* (line valid while idle) captures the line and the start chunk and enters `ST_SEND`. In `ST_SEND` it presents one beat at a time. The transition *advance* (a beat is taken, and it is not the last) moves to the next chunk. The transition *finish* (the last beat is taken) returns to `ST_IDLE`. While `beat_ready` is low, the machine holds its state.

Top module: `crit_chunk_unpacker`

## Requirements
- R1: After reset, `line_ready` is 1 and `beat_valid` is 0.
- R2: A line is taken on a clock edge where `line_valid` and `line_ready` are both 1. From the next cycle, `line_ready` stays 0 until the fourth beat of that line has been taken.
- R3: The first beat of a line carries chunk index `line_off[5:4]`.
- R4: Each later beat carries the previous chunk index plus one, modulo 4.
- R5: Beat bits [127:0] of a beat for chunk k equal line bits [128k+127:128k]. Beat bits [143:128] equal line bits [512+16k+15:512+16k], which are that chunk's two check bytes.
- R6: `beat_chunk` gives the chunk index k of the beat currently presented.
- R7: `beat_last` is 1 on the fourth beat of a line and 0 on the first three.
- R8: While `beat_valid` is 1 and `beat_ready` is 0, the beat data, index and last flag hold their values into the next cycle. No beat is lost or reordered.
- R9: After the fourth beat is taken, the next cycle has `line_ready` 1 and `beat_valid` 0. A `line_valid` raised while beats are still being sent has no effect on the beats of the current line.
- R10: Offset bits [3:0] have no effect on the beat order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | A line word is offered |
| line_ready | output | 1 | The block can take a line |
| line_data | input | 576 | Four data chunks in bits [511:0], four check pairs in bits [575:512] |
| line_off | input | 6 | Byte offset of the missed address within the line |
| beat_valid | output | 1 | A beat is presented |
| beat_ready | input | 1 | Downstream takes the beat |
| beat_data | output | 144 | Check pair in bits [143:128], data chunk in bits [127:0] |
| beat_chunk | output | 2 | Chunk index of the current beat |
| beat_last | output | 1 | The current beat is the fourth of its line |

## Verification
The assertions assume that the upstream side keeps `line_data` and `line_off` steady whenever `line_valid` is high and `line_ready` is high. They also assume that `beat_ready` is a free-running input that needs no prior valid. The bench changes `line_data` and `line_off` only on falling edges, and it holds the offered line until the edge at which it is taken. It deliberately raises `line_valid` with different data while a line is still being sent, to show that an offered line is ignored while the block is busy. The stall patterns hold `beat_ready` low for varying runs on arbitrary beats, which exercises every hold transition.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } unpk_state_e;
endpackage

// File: rtl/unpk_ctrl.sv
module unpk_ctrl
    import unpk_pkg::*;
#(
    parameter int NCHUNK = 4,
    localparam int IDX_W = $clog2(NCHUNK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_valid,
    input  logic             beat_ready,
    output logic             line_ready,
    output logic             beat_valid,
    output logic             load,
    output logic [IDX_W-1:0] step,
    output logic             last
);
    localparam logic [IDX_W-1:0] STEP_END = IDX_W'(NCHUNK - 1);

    unpk_state_e state_q, state_d;
    logic [IDX_W-1:0] step_q, step_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE: begin
                if (line_valid) begin          // load
                    state_d = ST_SEND;
                    step_d  = '0;
                end
            end
            ST_SEND: begin
                if (beat_ready) begin
                    if (step_q == STEP_END) begin   // finish
                        state_d = ST_IDLE;
                        step_d  = '0;
                    end else begin                  // advance
                        step_d = step_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // outputs
    always_comb begin
        line_ready = 1'b0;
        beat_valid = 1'b0;
        load       = 1'b0;
        last       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                line_ready = 1'b1;
                load       = line_valid;
            end
            ST_SEND: begin
                beat_valid = 1'b1;
                last       = (step_q == STEP_END);
            end
            default: ;
        endcase
        step = step_q;
    end
endmodule

// File: rtl/unpk_order.sv
module unpk_order #(
    parameter int NCHUNK = 4,
    localparam int IDX_W = $clog2(NCHUNK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] start_in,
    input  logic [IDX_W-1:0] step,
    output logic [IDX_W-1:0] chunk
);
    logic [IDX_W-1:0] start_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (load) begin
            start_q <= start_in;
        end
    end

    // wrapping order: the adder width performs the modulo
    assign chunk = start_q + step;
endmodule

// File: rtl/unpk_slice.sv
module unpk_slice #(
    parameter int NCHUNK  = 4,
    parameter int CHUNK_B = 16,
    parameter int ECC_B   = 2,
    localparam int CHUNK_W = CHUNK_B * 8,
    localparam int ECC_W   = ECC_B * 8,
    localparam int BEAT_W  = CHUNK_W + ECC_W,
    localparam int LINE_W  = NCHUNK * BEAT_W,
    localparam int DATA_W  = NCHUNK * CHUNK_W,
    localparam int IDX_W   = $clog2(NCHUNK)
) (
    input  logic              clk,
    input  logic              load,
    input  logic [LINE_W-1:0] line_in,
    input  logic [IDX_W-1:0]  chunk,
    output logic [BEAT_W-1:0] beat
);
    logic [LINE_W-1:0] line_q;
    logic [BEAT_W-1:0] pieces [NCHUNK];

    always_ff @(posedge clk) begin
        if (load) begin
            line_q <= line_in;
        end
    end

    // pair each data chunk with its own check bytes
    for (genvar k = 0; k < NCHUNK; k++) begin : g_piece
        assign pieces[k] = {line_q[DATA_W + k*ECC_W +: ECC_W],
                            line_q[k*CHUNK_W +: CHUNK_W]};
    end

    assign beat = pieces[chunk];
endmodule

// File: rtl/crit_chunk_unpacker.sv
module crit_chunk_unpacker #(
    parameter int NCHUNK  = 4,
    parameter int CHUNK_B = 16,
    parameter int ECC_B   = 2,
    localparam int CHUNK_W = CHUNK_B * 8,
    localparam int ECC_W   = ECC_B * 8,
    localparam int BEAT_W  = CHUNK_W + ECC_W,
    localparam int LINE_W  = NCHUNK * BEAT_W,
    localparam int IDX_W   = $clog2(NCHUNK),
    localparam int OFF_W   = $clog2(NCHUNK * CHUNK_B)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_valid,
    output logic              line_ready,
    input  logic [LINE_W-1:0] line_data,
    input  logic [OFF_W-1:0]  line_off,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [BEAT_W-1:0] beat_data,
    output logic [IDX_W-1:0]  beat_chunk,
    output logic              beat_last
);
    logic             load;
    logic [IDX_W-1:0] step;
    logic [IDX_W-1:0] start_idx;
    logic             unused_lo;

    assign start_idx = line_off[OFF_W-1 -: IDX_W];
    assign unused_lo = ^line_off[OFF_W-IDX_W-1:0];

    unpk_ctrl #(.NCHUNK(NCHUNK)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_valid (line_valid),
        .beat_ready (beat_ready),
        .line_ready (line_ready),
        .beat_valid (beat_valid),
        .load       (load),
        .step       (step),
        .last       (beat_last)
    );

    unpk_order #(.NCHUNK(NCHUNK)) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .start_in (start_idx),
        .step     (step),
        .chunk    (beat_chunk)
    );

    unpk_slice #(.NCHUNK(NCHUNK), .CHUNK_B(CHUNK_B), .ECC_B(ECC_B)) u_slice (
        .clk     (clk),
        .load    (load),
        .line_in (line_data),
        .chunk   (beat_chunk),
        .beat    (beat_data)
    );
endmodule

// File: rtl/unpk_chk.sv
module unpk_chk #(
    parameter int NCHUNK = 4,
    parameter int BEAT_W = 144,
    parameter int OFF_W  = 6,
    localparam int IDX_W = $clog2(NCHUNK)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_valid,
    input logic              line_ready,
    input logic [OFF_W-1:0]  line_off,
    input logic              beat_valid,
    input logic              beat_ready,
    input logic [BEAT_W-1:0] beat_data,
    input logic [IDX_W-1:0]  beat_chunk,
    input logic              beat_last
);
    localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NCHUNK - 1);

    logic [IDX_W-1:0] taken_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= '0;
        end else if (line_valid && line_ready) begin
            taken_q <= '0;
        end else if (beat_valid && beat_ready) begin
            taken_q <= taken_q + 1'b1;
        end
    end

    // R2
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_ready && beat_valid));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && line_ready) |=> (beat_valid && !line_ready));

    // R3
    first_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && line_ready) |=> (beat_chunk == $past(line_off[OFF_W-1 -: IDX_W])));

    // R4
    wrap_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && !beat_last) |=>
            (beat_valid && (beat_chunk - $past(beat_chunk)) == ONE));

    // R7
    last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_last == (taken_q == LAST)));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=>
            (beat_valid && $stable(beat_data) && $stable(beat_chunk) && $stable(beat_last)));

    // R9
    finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && beat_last) |=> (line_ready && !beat_valid));
endmodule

bind crit_chunk_unpacker unpk_chk #(
    .NCHUNK (NCHUNK),
    .BEAT_W (BEAT_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_valid (line_valid),
    .line_ready (line_ready),
    .line_off   (line_off),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_data  (beat_data),
    .beat_chunk (beat_chunk),
    .beat_last  (beat_last)
);

// File: tb/sim_crit_chunk_unpacker.sv
`timescale 1ns/1ps
module sim_crit_chunk_unpacker;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_valid = 1'b0;
    logic         line_ready;
    logic [575:0] line_data = '0;
    logic [5:0]   line_off = '0;
    logic         beat_valid;
    logic         beat_ready = 1'b0;
    logic [143:0] beat_data;
    logic [1:0]   beat_chunk;
    logic         beat_last;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    crit_chunk_unpacker u0 (
        .clk(clk), .rst_n(rst_n),
        .line_valid(line_valid), .line_ready(line_ready),
        .line_data(line_data), .line_off(line_off),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_data(beat_data), .beat_chunk(beat_chunk), .beat_last(beat_last)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [159:0] act, input logic [159:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [575:0] mk_line(input int seed);
        logic [575:0] l;
        for (int i = 0; i < 72; i++) l[i*8 +: 8] = 8'((seed * 37 + i * 13 + 5) & 255);
        return l;
    endfunction

    function automatic logic [143:0] exp_beat(input logic [575:0] l, input int k);
        return {l[512 + 16*k +: 16], l[128*k +: 128]};
    endfunction

    // one line, with STALL cycles before each take; INTRUDE offers another line while busy
    task automatic run_line(input logic [575:0] ln, input logic [5:0] off,
                            input int stall, input bit intrude);
        int start;
        start = int'(off[5:4]);
        @(negedge clk);
        chk(line_ready == 1'b1, "R2 ready before offer", 160'(line_ready), 160'(1));
        line_valid = 1'b1; line_data = ln; line_off = off;
        @(negedge clk);
        line_valid = intrude;
        if (intrude) begin line_data = ~ln; line_off = ~off; end
        chk(line_ready == 1'b0, "R2 busy after accept", 160'(line_ready), 160'(0));
        for (int b = 0; b < 4; b++) begin
            logic [143:0] held;
            int k;
            k = (start + b) % 4;
            for (int s = 0; s < stall; s++) begin
                beat_ready = 1'b0;
                held = beat_data;
                @(negedge clk);
                chk(beat_valid && beat_data == held, "R8 hold on stall",
                    160'(beat_data), 160'(held));
                chk(line_ready == 1'b0, "R9 intruding line ignored", 160'(line_ready), 160'(0));
            end
            chk(beat_valid == 1'b1, "R2 beat valid", 160'(beat_valid), 160'(1));
            if (b == 0) chk(beat_chunk == 2'(k), "R3 first chunk R10", 160'(beat_chunk), 160'(k));
            else        chk(beat_chunk == 2'(k), "R4 wrap order R6", 160'(beat_chunk), 160'(k));
            chk(beat_data == exp_beat(ln, k), "R5 beat content", 160'(beat_data),
                160'(exp_beat(ln, k)));
            chk(beat_last == (b == 3), "R7 last flag", 160'(beat_last), 160'(b == 3));
            beat_ready = 1'b1;
            @(negedge clk);
        end
        beat_ready = 1'b0;
        line_valid = 1'b0;
        chk(line_ready == 1'b1 && beat_valid == 1'b0, "R9 idle after finish",
            160'({line_ready, beat_valid}), 160'(2'b10));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(line_ready == 1'b1, "R1 reset ready", 160'(line_ready), 160'(1));
        chk(beat_valid == 1'b0, "R1 reset valid", 160'(beat_valid), 160'(0));
        rst_n = 1'b1;
    endtask

    task automatic t_aligned();   run_line(mk_line(1), 6'h00, 0, 1'b0); endtask
    task automatic t_chunk1();    run_line(mk_line(2), 6'h10, 0, 1'b0); endtask
    task automatic t_low_bits();  run_line(mk_line(3), 6'h2F, 2, 1'b0); endtask
    task automatic t_intrude();   run_line(mk_line(4), 6'h3C, 1, 1'b1); endtask
    task automatic t_low_same();  run_line(mk_line(5), 6'h27, 0, 1'b0); endtask
    task automatic t_long_stall(); run_line(mk_line(6), 6'h31, 5, 1'b1); endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_aligned();
        t_chunk1();
        t_low_bits();
        t_intrude();
        t_low_same();
        t_long_stall();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule